// File: doc/BRIEF.md
# Binary32 Significand Rounding Stage

This block is the final rounding step of a single-precision floating-point datapath. The upstream normalizer delivers a 24-bit significand with its hidden bit at the top. Alongside it come two bits that describe what was shifted away. The first is the half-ulp bit, the highest discarded position. The second is a sticky bit, the OR of every discarded position below the half-ulp bit. The normalizer has already folded any further guard position into these two bits. The block also receives the sign and the biased exponent.

Purely combinational logic picks one of four rounding directions and decides whether to add one unit in the last place. It then renormalizes if that increment carries out of the significand. It returns the 23 stored fraction bits and the final exponent. Two flags report a lost value and an exponent that has run out of range. The input is assumed to be a finite, normalized value with a biased exponent from 1 to 254. Special operands and traps are handled elsewhere.

Top module: `frnd_unit`

## Requirements
- R1: With mode 2'b00 (nearest, ties to even), one ulp is added exactly when the half-ulp bit is set and either the sticky bit or the significand LSB is set.
- R2: In mode 2'b00, an input exactly halfway (half-ulp set, sticky clear) yields a result whose fraction LSB is 0.
- R3: With mode 2'b01 (toward zero), the fraction output equals the low 23 input significand bits and the exponent is unchanged, whatever the discarded bits are.
- R4: With mode 2'b10 (toward positive infinity), one ulp is added when any discarded bit is set and the sign is 0; a negative value is truncated.
- R5: With mode 2'b11 (toward negative infinity), one ulp is added when any discarded bit is set and the sign is 1; a positive value is truncated.
- R6: When the increment carries out of the 24-bit significand, the fraction output is zero and the exponent output is the input exponent plus one.
- R7: When the rounded exponent reaches 255, overflow is 1 and the result is infinity: exponent 8'hFF and fraction zero.
- R8: At exponent 254 with an all-ones significand, a mode that does not increment returns the largest finite value (exponent 254, fraction all ones) with overflow 0.
- R9: inexact equals the OR of the half-ulp and sticky bits in every mode; with both clear, every mode returns the input fraction and exponent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sign_in | input | 1 | Sign of the value, 1 = negative |
| exp_in | input | 8 | Biased exponent before rounding |
| sig_in | input | 24 | Normalized significand, bit 23 is the hidden one |
| rnd_in | input | 1 | Half-ulp bit, first position below the LSB |
| stk_in | input | 1 | OR of all discarded bits below the half-ulp bit |
| mode_in | input | 2 | Rounding direction: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| frac_out | output | 23 | Rounded stored fraction |
| exp_out | output | 8 | Exponent after rounding |
| inexact | output | 1 | A nonzero value was discarded |
| overflow | output | 1 | Rounded exponent left the finite range |

## Verification
The carry-out renormalization and the overflow flag can fall in the same evaluation. This happens when an all-ones significand at exponent 254 is rounded up. The bench provokes it in nearest-even mode, and in each infinity-directed mode with the matching sign. It expects exponent 255, a zero fraction, and both overflow and inexact set. The same significand and exponent under toward-zero or opposite-sign directed rounding must stay at the largest finite value with overflow clear. That shows the two effects separate cleanly when no increment occurs.

// File: rtl/frnd_unit.sv
module frnd_unit #(
  parameter int FRAC_W = 23,
  parameter int EXP_W  = 8
) (
  input  logic              sign_in,
  input  logic [EXP_W-1:0]  exp_in,
  input  logic [FRAC_W:0]   sig_in,
  input  logic              rnd_in,
  input  logic              stk_in,
  input  logic [1:0]        mode_in,
  output logic [FRAC_W-1:0] frac_out,
  output logic [EXP_W-1:0]  exp_out,
  output logic              inexact,
  output logic              overflow
);
  localparam int SIG_W = FRAC_W + 1;
  localparam logic [EXP_W:0] EXP_TOP = {1'b0, {EXP_W{1'b1}}};
  localparam logic [1:0] M_RNE = 2'b00;
  localparam logic [1:0] M_RTZ = 2'b01;
  localparam logic [1:0] M_RUP = 2'b10;
  localparam logic [1:0] M_RDN = 2'b11;

  logic             lost;
  logic             bump;
  logic [SIG_W:0]   sum;
  logic             carry;
  logic [EXP_W:0]   exp_w;

  assign lost = rnd_in | stk_in;

  always_comb begin
    case (mode_in)
      M_RNE:   bump = rnd_in & (stk_in | sig_in[0]);
      M_RTZ:   bump = 1'b0;
      M_RUP:   bump = lost & ~sign_in;
      M_RDN:   bump = lost & sign_in;
      default: bump = 1'b0;
    endcase
  end

  assign sum   = {1'b0, sig_in} + {{SIG_W{1'b0}}, bump};
  assign carry = sum[SIG_W];
  assign exp_w = {1'b0, exp_in} + {{EXP_W{1'b0}}, carry};

  assign overflow = exp_w >= EXP_TOP;
  assign exp_out  = overflow ? EXP_TOP[EXP_W-1:0] : exp_w[EXP_W-1:0];
  assign frac_out = overflow ? '0 : (carry ? sum[FRAC_W:1] : sum[FRAC_W-1:0]);
  assign inexact  = lost;
endmodule

module frnd_unit_chk #(
  parameter int FRAC_W = 23,
  parameter int EXP_W  = 8
) (
  input logic              sign_in,
  input logic [EXP_W-1:0]  exp_in,
  input logic [FRAC_W:0]   sig_in,
  input logic              rnd_in,
  input logic              stk_in,
  input logic [1:0]        mode_in,
  input logic [FRAC_W-1:0] frac_out,
  input logic [EXP_W-1:0]  exp_out,
  input logic              inexact,
  input logic              overflow
);
  localparam logic [EXP_W-1:0] ONE_E = 1;

  always_comb begin
    if (mode_in == 2'b01)
      assert_rtz_trunc_R3: assert (frac_out == sig_in[FRAC_W-1:0] && exp_out == exp_in);
    assert_inexact_R9: assert (inexact == (rnd_in | stk_in));
    if (overflow)
      assert_ovf_inf_R7: assert (&exp_out && frac_out == '0 && inexact);
    if (mode_in == 2'b00 && rnd_in && !stk_in && !overflow)
      assert_tie_even_R2: assert (frac_out[0] == 1'b0);
    if (!overflow && exp_out != exp_in)
      assert_carry_renorm_R6: assert (frac_out == '0 && exp_out == exp_in + ONE_E);
    if (mode_in == 2'b10 && sign_in)
      assert_rup_neg_trunc_R4: assert (frac_out == sig_in[FRAC_W-1:0]);
    if (mode_in == 2'b11 && !sign_in)
      assert_rdn_pos_trunc_R5: assert (frac_out == sig_in[FRAC_W-1:0]);
  end
endmodule

bind frnd_unit frnd_unit_chk #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_chk (
  .sign_in(sign_in), .exp_in(exp_in), .sig_in(sig_in), .rnd_in(rnd_in),
  .stk_in(stk_in), .mode_in(mode_in), .frac_out(frac_out), .exp_out(exp_out),
  .inexact(inexact), .overflow(overflow)
);

// File: tb/frnd_unit_test.sv
module frnd_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2ns clk = ~clk;

  logic        sign_in;
  logic [7:0]  exp_in;
  logic [23:0] sig_in;
  logic        rnd_in, stk_in;
  logic [1:0]  mode_in;
  logic [22:0] frac_out;
  logic [7:0]  exp_out;
  logic        inexact, overflow;

  int checks = 0;
  int failures = 0;

  frnd_unit uut (
    .sign_in(sign_in), .exp_in(exp_in), .sig_in(sig_in), .rnd_in(rnd_in),
    .stk_in(stk_in), .mode_in(mode_in), .frac_out(frac_out), .exp_out(exp_out),
    .inexact(inexact), .overflow(overflow)
  );

  task automatic apply(input logic s, input logic [7:0] e, input logic [23:0] m,
                       input logic r, input logic st, input logic [1:0] md);
    @(negedge clk);
    sign_in = s; exp_in = e; sig_in = m; rnd_in = r; stk_in = st; mode_in = md;
    @(posedge clk);
    #1ns;
  endtask

  task automatic expect_out(input string req, input logic [22:0] f, input logic [7:0] e,
                            input logic inx, input logic ovf);
    checks++;
    if (frac_out !== f || exp_out !== e || inexact !== inx || overflow !== ovf) begin
      failures++;
      $display("FAIL %s: got frac=%h exp=%h inx=%b ovf=%b, expected frac=%h exp=%h inx=%b ovf=%b",
               req, frac_out, exp_out, inexact, overflow, f, e, inx, ovf);
    end
  endtask

  task automatic t_idle;
    apply(1'b0, 8'd0, 24'h000000, 1'b0, 1'b0, 2'b00);
    expect_out("R9 idle", 23'h0, 8'd0, 1'b0, 1'b0);
  endtask

  task automatic t_nearest;
    apply(1'b0, 8'd100, 24'h800001, 1'b1, 1'b0, 2'b00);
    expect_out("R1 tie odd up", 23'h000002, 8'd100, 1'b1, 1'b0);
    apply(1'b0, 8'd100, 24'h800000, 1'b1, 1'b1, 2'b00);
    expect_out("R1 above half", 23'h000001, 8'd100, 1'b1, 1'b0);
    apply(1'b1, 8'd100, 24'h800001, 1'b0, 1'b1, 2'b00);
    expect_out("R1 below half", 23'h000001, 8'd100, 1'b1, 1'b0);
  endtask

  task automatic t_tie;
    apply(1'b0, 8'd77, 24'h800002, 1'b1, 1'b0, 2'b00);
    expect_out("R2 tie even stays", 23'h000002, 8'd77, 1'b1, 1'b0);
    apply(1'b1, 8'd77, 24'hC00003, 1'b1, 1'b0, 2'b00);
    expect_out("R2 tie odd to even", 23'h400004, 8'd77, 1'b1, 1'b0);
  endtask

  task automatic t_rtz;
    apply(1'b0, 8'd10, 24'hFFFFFF, 1'b1, 1'b1, 2'b01);
    expect_out("R3 truncate pos", 23'h7FFFFF, 8'd10, 1'b1, 1'b0);
    apply(1'b1, 8'd10, 24'h812345, 1'b1, 1'b0, 2'b01);
    expect_out("R3 truncate neg", 23'h012345, 8'd10, 1'b1, 1'b0);
  endtask

  task automatic t_up;
    apply(1'b0, 8'd50, 24'h800000, 1'b0, 1'b1, 2'b10);
    expect_out("R4 pos up", 23'h000001, 8'd50, 1'b1, 1'b0);
    apply(1'b1, 8'd50, 24'h800000, 1'b1, 1'b1, 2'b10);
    expect_out("R4 neg truncate", 23'h000000, 8'd50, 1'b1, 1'b0);
  endtask

  task automatic t_down;
    apply(1'b1, 8'd50, 24'h800004, 1'b1, 1'b0, 2'b11);
    expect_out("R5 neg up", 23'h000005, 8'd50, 1'b1, 1'b0);
    apply(1'b0, 8'd50, 24'h800004, 1'b1, 1'b1, 2'b11);
    expect_out("R5 pos truncate", 23'h000004, 8'd50, 1'b1, 1'b0);
  endtask

  task automatic t_carry;
    apply(1'b0, 8'd100, 24'hFFFFFF, 1'b1, 1'b0, 2'b00);
    expect_out("R6 carry nearest", 23'h0, 8'd101, 1'b1, 1'b0);
    apply(1'b1, 8'd1, 24'hFFFFFF, 1'b0, 1'b1, 2'b11);
    expect_out("R6 carry down neg", 23'h0, 8'd2, 1'b1, 1'b0);
  endtask

  task automatic t_ovf;
    apply(1'b0, 8'd254, 24'hFFFFFF, 1'b1, 1'b1, 2'b00);
    expect_out("R7 ovf nearest", 23'h0, 8'hFF, 1'b1, 1'b1);
    apply(1'b0, 8'd254, 24'hFFFFFF, 1'b0, 1'b1, 2'b10);
    expect_out("R7 ovf up pos", 23'h0, 8'hFF, 1'b1, 1'b1);
    apply(1'b1, 8'd254, 24'hFFFFFF, 1'b1, 1'b0, 2'b11);
    expect_out("R7 ovf down neg", 23'h0, 8'hFF, 1'b1, 1'b1);
  endtask

  task automatic t_max;
    apply(1'b0, 8'd254, 24'hFFFFFF, 1'b1, 1'b1, 2'b01);
    expect_out("R8 max rtz", 23'h7FFFFF, 8'd254, 1'b1, 1'b0);
    apply(1'b1, 8'd254, 24'hFFFFFF, 1'b1, 1'b1, 2'b10);
    expect_out("R8 max up neg", 23'h7FFFFF, 8'd254, 1'b1, 1'b0);
    apply(1'b0, 8'd254, 24'hFFFFFF, 1'b1, 1'b1, 2'b11);
    expect_out("R8 max down pos", 23'h7FFFFF, 8'd254, 1'b1, 1'b0);
  endtask

  task automatic t_exact;
    for (int md = 0; md < 4; md++) begin
      apply(md[0], 8'd254, 24'hFFFFFF, 1'b0, 1'b0, md[1:0]);
      expect_out("R9 exact unchanged", 23'h7FFFFF, 8'd254, 1'b0, 1'b0);
    end
    apply(1'b0, 8'd33, 24'hA5A5A4, 1'b1, 1'b0, 2'b11);
    expect_out("R9 inexact no bump", 23'h25A5A4, 8'd33, 1'b1, 1'b0);
  endtask

  initial begin
    sign_in = 1'b0; exp_in = '0; sig_in = '0; rnd_in = 1'b0; stk_in = 1'b0; mode_in = 2'b00;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_idle();
    t_nearest();
    t_tie();
    t_rtz();
    t_up();
    t_down();
    t_carry();
    t_ovf();
    t_max();
    t_exact();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400us;
    checks++;
    failures++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule